// File: doc/BRIEF.md
# Multi-Length Round-Key Schedule Generator

This block turns a cipher key of 128, 192 or 256 bits into the complete round-key schedule of the standard block cipher and keeps it in local storage. A cipher datapath then fetches any round key by index. The key always enters on one 256-bit bus with its most significant bit at bit 255. A two-bit code selects the key length.

A one-cycle start strobe captures the key and the length code. The first words of the key go straight into storage. After that, one new 32-bit schedule word is produced in each enabled cycle. A single four-byte substitution unit serves both the rotated word and the 256-bit mid-block word.

When the last word is written, a ready flag rises. It then stays high until the next start. Encryption and decryption rounds read from the same stored words, so changing direction never calls for a second expansion. A low enable freezes the sequence in place.

Top module: `key_sched_unit`

## Requirements
- R1: Length code 2'b00 selects a 128-bit key taken from bits [255:128]. The schedule has 44 words, which is 11 round keys. Round 10 of key 2b7e151628aed2a6abf7158809cf4f3c reads d014f9a8c9ee2589e13f0cc8b6630ca6.
- R2: Length code 2'b01 selects a 192-bit key taken from bits [255:64]. The schedule has 52 words, which is 13 round keys. Round 12 of key 8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b reads e98ba06f448c773c8ecc720401002202.
- R3: Length code 2'b10 selects a 256-bit key that fills the whole bus. The schedule has 60 words, which is 15 round keys. In this mode a word whose index modulo 8 is 4 is substituted with no rotation and no round constant. Round 14 of key 603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4 reads fe4890d1e6188d0b046df344706c631e.
- R4: The cycle after a start with a valid code, key_rdy is low. It rises after exactly 40, 46 or 52 further enabled clock edges for 128-, 192- or 256-bit keys. It then stays high until the next start.
- R5: While en is low, the expansion holds its state. Each low cycle delays key_rdy by one edge, and the schedule that results is unchanged.
- R6: A start with the reserved code 2'b11 drops key_rdy and starts no expansion. The stored words stay as they were.
- R7: A start that arrives during an expansion abandons the old expansion and restarts with the new key and length.
- R8: Reset clears key_rdy and the internal sequencing state.
- R9: rk_idx = i returns schedule words 4i to 4i+3 on rk_out, with word 4i in bits [127:96]. Round 0 equals the key itself.
- R10: Once key_rdy is high, every round key can be read any number of times, in any order. The values stay stable, with no new expansion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global advance enable |
| start | input | 1 | One-cycle strobe that captures key_bus and key_len |
| key_len | input | 2 | Key length code: 00 = 128, 01 = 192, 10 = 256, 11 = reserved |
| key_bus | input | 256 | Cipher key, MSB-aligned |
| key_rdy | output | 1 | High while a complete schedule is stored |
| rk_idx | input | 4 | Round-key read index |
| rk_out | output | 128 | Round key selected by rk_idx |

## Verification
The assertions assume that start lasts a single cycle and that rk_idx changes only when the bench wants a new read. The stability property compares rk_out against a steady index while a ready schedule is held. The bench drives every input on the falling edge, holds start for one cycle at a time and keeps rk_idx within the rounds of the current length. Pauses of the enable are placed only in the middle of an expansion.

// File: rtl/ks_pkg.sv
package ks_pkg;
    localparam int KEY_W     = 256;
    localparam int WORD_W    = 32;
    localparam int MAX_WORDS = 60;
    localparam int ADDR_W    = $clog2(MAX_WORDS);
    localparam int RK_W      = 4 * WORD_W;
    localparam int RK_IDX_W  = $clog2(MAX_WORDS / 4);
    localparam int NK_W      = 4;

    typedef struct packed {
        logic              busy;
        logic              rdy;
        logic [ADDR_W-1:0] idx;
        logic [2:0]        pos;
        logic [7:0]        rcon;
        logic [NK_W-1:0]   nk;
        logic [ADDR_W-1:0] last;
    } ks_state_t;

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // multiplicative inverse as a^254 through an addition chain
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p2, p3, p12, p15, p240, p252;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p12  = gf_mul(gf_mul(p3, p3), gf_mul(p3, p3));
        p15  = gf_mul(p12, p3);
        p240 = gf_mul(p15, p15);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p252 = gf_mul(p240, p12);
        return gf_mul(p252, p2);
    endfunction

    function automatic logic [7:0] sub_byte(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    // words per key for a length code, zero for the reserved code
    function automatic logic [NK_W-1:0] nk_of(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd4;
            2'b01:   return 4'd6;
            2'b10:   return 4'd8;
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/ks_subword.sv
module ks_subword
    import ks_pkg::*;
(
    input  logic [WORD_W-1:0] w_in,
    output logic [WORD_W-1:0] w_out
);
    localparam int NBYTES = WORD_W / 8;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign w_out[g*8 +: 8] = sub_byte(w_in[g*8 +: 8]);
    end
endmodule

// File: rtl/ks_word_mem.sv
module ks_word_mem
    import ks_pkg::*;
#(
    parameter int DEPTH = MAX_WORDS
) (
    input  logic                clk,
    input  logic                load,
    input  logic [KEY_W-1:0]    load_words,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]   ra_addr,
    output logic [WORD_W-1:0]   ra_data,
    input  logic [ADDR_W-1:0]   rb_addr,
    output logic [WORD_W-1:0]   rb_data,
    input  logic [RK_IDX_W-1:0] rk_idx,
    output logic [RK_W-1:0]     rk_out
);
    localparam int LOAD_N = KEY_W / WORD_W;
    localparam int RK_N   = RK_W / WORD_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < LOAD_N; i++)
                mem[i] <= load_words[KEY_W-1-i*WORD_W -: WORD_W];
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign ra_data = (int'(ra_addr) < DEPTH) ? mem[ra_addr] : '0;
    assign rb_data = (int'(rb_addr) < DEPTH) ? mem[rb_addr] : '0;

    for (genvar g = 0; g < RK_N; g++) begin : g_rk
        logic [ADDR_W-1:0] a;
        assign a = {rk_idx, 2'(g)};
        assign rk_out[RK_W-1-g*WORD_W -: WORD_W] = (int'(a) < DEPTH) ? mem[a] : '0;
    end
endmodule

// File: rtl/key_sched_unit.sv
module key_sched_unit
    import ks_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                start,
    input  logic [1:0]          key_len,
    input  logic [KEY_W-1:0]    key_bus,
    output logic                key_rdy,
    input  logic [RK_IDX_W-1:0] rk_idx,
    output logic [RK_W-1:0]     rk_out
);
    ks_state_t st_q, st_d;

    logic [NK_W-1:0]   nk_sel;
    logic              len_ok;
    logic              busy_w;
    logic              step;
    logic [WORD_W-1:0] prev_w, back_w, sub_in, sub_out, temp_w, new_w;
    logic [ADDR_W-1:0] prev_a, back_a;
    logic              first_of_blk, mid_of_blk;

    assign nk_sel = nk_of(key_len);
    assign len_ok = (nk_sel != '0);
    assign busy_w = st_q.busy;
    assign step   = busy_w && en && !start;

    assign prev_a = st_q.idx - ADDR_W'(1);
    assign back_a = st_q.idx - ADDR_W'(st_q.nk);

    // word role inside its key-length block
    assign first_of_blk = (st_q.pos == 3'd0);
    assign mid_of_blk   = (st_q.nk == 4'd8) && (st_q.pos == 3'd4);

    assign sub_in = first_of_blk ? {prev_w[WORD_W-9:0], prev_w[WORD_W-1 -: 8]} : prev_w;

    ks_subword u_sub (
        .w_in  (sub_in),
        .w_out (sub_out)
    );

    always_comb begin
        if (first_of_blk)    temp_w = sub_out ^ {st_q.rcon, 24'h0};
        else if (mid_of_blk) temp_w = sub_out;
        else                 temp_w = prev_w;
    end
    assign new_w = back_w ^ temp_w;

    ks_word_mem #(.DEPTH(MAX_WORDS)) u_mem (
        .clk        (clk),
        .load       (start && len_ok),
        .load_words (key_bus),
        .we         (step),
        .waddr      (st_q.idx),
        .wdata      (new_w),
        .ra_addr    (prev_a),
        .ra_data    (prev_w),
        .rb_addr    (back_a),
        .rb_data    (back_w),
        .rk_idx     (rk_idx),
        .rk_out     (rk_out)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = len_ok;
            st_d.rdy  = 1'b0;
            st_d.nk   = nk_sel;
            st_d.idx  = ADDR_W'(nk_sel);
            st_d.pos  = 3'd0;
            st_d.rcon = 8'h01;
            st_d.last = ADDR_W'(4 * (int'(nk_sel) + 7) - 1);
        end else if (step) begin
            st_d.idx = st_q.idx + ADDR_W'(1);
            st_d.pos = ({1'b0, st_q.pos} == st_q.nk - 4'd1) ? 3'd0 : st_q.pos + 3'd1;
            if (first_of_blk) st_d.rcon = xtime(st_q.rcon);
            if (st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.rdy  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_rdy = st_q.rdy;
endmodule

// File: rtl/key_sched_unit_chk.sv
module key_sched_unit_chk
    import ks_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic                start,
    input logic [1:0]          key_len,
    input logic                key_rdy,
    input logic                busy,
    input logic [RK_IDX_W-1:0] rk_idx,
    input logic [RK_W-1:0]     rk_out
);
    AST_START_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        start && key_len != 2'b11 |=> busy && !key_rdy);                 // R4
    AST_RDY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        key_rdy && !start |=> key_rdy);                                  // R4
    AST_BUSY_NOT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !key_rdy);                                              // R4
    AST_EN_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !start |=> $stable(busy) && $stable(key_rdy));            // R5
    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start && key_len == 2'b11 |=> !busy && !key_rdy);                // R6
    AST_RESTART_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && key_len != 2'b11 |=> busy);                     // R7
    AST_RK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_rdy && $past(key_rdy) && $stable(rk_idx) |-> $stable(rk_out)); // R10
endmodule

bind key_sched_unit key_sched_unit_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .start   (start),
    .key_len (key_len),
    .key_rdy (key_rdy),
    .busy    (busy_w),
    .rk_idx  (rk_idx),
    .rk_out  (rk_out)
);

// File: tb/key_sched_unit_tb_top.sv
module key_sched_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    localparam logic [127:0] K128 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [191:0] K192 = 192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b;
    localparam logic [255:0] K256 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

    typedef struct packed {
        logic [1:0]   len;
        logic [255:0] key;
        logic [3:0]   rnd;
        logic [127:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'b00, {K128, 128'h0}, 4'd0,  128'h2b7e151628aed2a6abf7158809cf4f3c},
        '{2'b00, {K128, 128'h0}, 4'd1,  128'ha0fafe1788542cb123a339392a6c7605},
        '{2'b00, {K128, 128'h0}, 4'd10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
        '{2'b01, {K192, 64'h0},  4'd1,  128'h62f8ead2522c6b7bfe0c91f72402f5a5},
        '{2'b01, {K192, 64'h0},  4'd12, 128'he98ba06f448c773c8ecc720401002202},
        '{2'b10, K256,           4'd2,  128'h9ba354118e6925afa51a8b5f2067fcde},
        '{2'b10, K256,           4'd14, 128'hfe4890d1e6188d0b046df344706c631e}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   key_len = 2'b00;
    logic [255:0] key_bus = '0;
    logic         key_rdy;
    logic [3:0]   rk_idx = '0;
    logic [127:0] rk_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_sched_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .start   (start),
        .key_len (key_len),
        .key_bus (key_bus),
        .key_rdy (key_rdy),
        .rk_idx  (rk_idx),
        .rk_out  (rk_out)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int edges_for(input logic [1:0] len);
        case (len)
            2'b00:   return 40;
            2'b01:   return 46;
            default: return 52;
        endcase
    endfunction

    // pulse start for one edge; returns at the following falling edge
    task automatic pulse(input logic [1:0] len, input logic [255:0] key);
        key_len = len;
        key_bus = key;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        key_bus = '0;
    endtask

    task automatic read_rk(input logic [3:0] r, output logic [127:0] v);
        rk_idx = r;
        #1;
        v = rk_out;
    endtask

    // R4: exact number of edges before key_rdy rises
    task automatic expand_timed(input logic [1:0] len, input logic [255:0] key, input string req);
        int n;
        n = edges_for(len);
        pulse(len, key);
        chk({req, "/R4 low after start"}, 128'(key_rdy), 128'(0));
        repeat (n - 1) @(negedge clk);
        chk({req, "/R4 low one edge early"}, 128'(key_rdy), 128'(0));
        @(negedge clk);
        chk({req, "/R4 high on time"}, 128'(key_rdy), 128'(1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] v, v2;
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 ready low in reset", 128'(key_rdy), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 ready low after reset", 128'(key_rdy), 128'(0));

        // table walk: R1 R2 R3 R9
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = (VECS[i].len == 2'b00) ? "R1" : (VECS[i].len == 2'b01) ? "R2" : "R3";
            expand_timed(VECS[i].len, VECS[i].key, tag);
            read_rk(VECS[i].rnd, v);
            chk({tag, "/R9 round key"}, v, VECS[i].exp);
        end

        // R10: repeated reads after a long idle time, in either order
        repeat (100) @(negedge clk);
        chk("R10 ready kept", 128'(key_rdy), 128'(1));
        read_rk(4'd14, v);
        read_rk(4'd0, v2);
        chk("R10 round 0 again", v2, K256[255:128]);
        read_rk(4'd14, v2);
        chk("R10 round 14 again", v2, v);

        // R6: reserved code drops ready, starts nothing, keeps storage
        pulse(2'b11, {K128, 128'h0});
        chk("R6 ready low after reserved", 128'(key_rdy), 128'(0));
        repeat (80) @(negedge clk);
        chk("R6 ready stays low", 128'(key_rdy), 128'(0));
        read_rk(4'd14, v2);
        chk("R6 storage untouched", v2, 128'hfe4890d1e6188d0b046df344706c631e);

        // R5: enable low pauses the 192-bit expansion for 7 cycles
        pulse(2'b01, {K192, 64'h0});
        repeat (5) @(negedge clk);
        en = 1'b0;
        repeat (7) @(negedge clk);
        chk("R5 ready low while paused", 128'(key_rdy), 128'(0));
        en = 1'b1;
        repeat (46 - 5 - 1) @(negedge clk);
        chk("R5 ready delayed by pause", 128'(key_rdy), 128'(0));
        @(negedge clk);
        chk("R5 ready after pause", 128'(key_rdy), 128'(1));
        read_rk(4'd12, v);
        chk("R5 result unchanged", v, 128'he98ba06f448c773c8ecc720401002202);

        // R7: restart mid-expansion with a different length
        pulse(2'b00, {K128, 128'h0});
        repeat (10) @(negedge clk);
        expand_timed(2'b10, K256, "R7");
        read_rk(4'd14, v);
        chk("R7 restarted schedule", v, 128'hfe4890d1e6188d0b046df344706c631e);
        read_rk(4'd2, v);
        chk("R7/R3 mid-block word rule", v, 128'h9ba354118e6925afa51a8b5f2067fcde);

        // R8: reset after completion clears ready
        rst_n = 1'b0;
        #1;
        chk("R8 ready cleared by reset", 128'(key_rdy), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 ready still low", 128'(key_rdy), 128'(0));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule